// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, every cycle, where the two execute-stage operands of a five-stage pipeline should come from. Each operand may be taken from the result held in the execute/memory pipeline register, from the result held in the memory/writeback pipeline register, or from the value read out of the register file. The block compares each operand's source register number with the destination register numbers carried by the two later stages and emits a 2-bit select code per operand. The multiplexers themselves sit outside.

A second, narrower path serves stores. When the instruction in the memory stage is a store whose data register is being written by the instruction now in writeback, the block raises a 1-bit select that steers the writeback value onto the store-data input of data memory. No select exists for the memory address input, because the address always comes straight from the ALU result. No path into decode is needed either, because the register file writes in the first half of a cycle and reads in the second half.

The selects are purely combinational functions of the stage fields. The clock and reset ports only time the embedded checks. Stall generation, the register file and the multiplexer datapath are all outside this block.

Top module: `fwd_select_unit`

## Requirements
- R1: Operand A select is 0 (execute/memory result) whenever ex_rs1 equals xm_rd while xm_we is 1 and xm_rd is nonzero.
- R2: When R1 does not apply, operand A select is 1 (memory/writeback result) if ex_rs1 equals mw_rd while mw_we is 1 and mw_rd is nonzero.
- R3: When neither later stage qualifies, operand A select is 2 (register-file value).
- R4: Operand B select follows the same rules using ex_rs2, and it is computed independently of operand A.
- R5: When both later stages write the same source register, the execute/memory stage (the younger producer) wins and the select is 0.
- R6: A stage whose write enable is 0 never causes a match, whatever its destination field holds.
- R7: Register 0 never matches: a source field of 0 always yields select 2.
- R8: The store-data select is 1 when mem_is_store is 1, mw_we is 1, mw_rd is nonzero and mem_st_rs equals mw_rd; otherwise it is 0.
- R9: The store-data select is 0 whenever mem_is_store is 0, even if the register fields match.
- R10: The code 3 never appears on either operand select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times the embedded checks |
| rst | input | 1 | Synchronous active-high reset; disables the checks |
| ex_rs1 | input | ADDR_W | Execute-stage source register for ALU operand A |
| ex_rs2 | input | ADDR_W | Execute-stage source register for ALU operand B |
| xm_we | input | 1 | Execute/memory stage writes a register |
| xm_rd | input | ADDR_W | Execute/memory stage destination register |
| mw_we | input | 1 | Memory/writeback stage writes a register |
| mw_rd | input | ADDR_W | Memory/writeback stage destination register |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_rs | input | ADDR_W | Memory-stage store data register |
| sel_a | output | 2 | Operand A select: 0 = execute/memory, 1 = memory/writeback, 2 = register file |
| sel_b | output | 2 | Operand B select, same encoding |
| sel_st | output | 1 | 1 = take writeback value as store data |

## Verification
The hardest case to reach is a double producer: both later stages must name the same destination while both write enables are high, so that the priority between them decides the result. A real pipeline reaches this only with back-to-back writes to one register. The bench drives that field combination directly. It then removes each enable in turn, so that priority, enable gating and register-0 exclusion are each seen in isolation. The same rs fields are also presented with the store flag dropped, to show that the store path depends on the store flag alone.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int unsigned REG_AW = 5;
    localparam int unsigned N_OPND = 2;

    typedef enum logic [1:0] {
        SEL_XM = 2'd0,
        SEL_MW = 2'd1,
        SEL_RF = 2'd2
    } opnd_sel_e;

    // Youngest producer takes priority.
    function automatic opnd_sel_e pick_source(input logic hit_xm, input logic hit_mw);
        if (hit_xm)      return SEL_XM;
        else if (hit_mw) return SEL_MW;
        else             return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          dst_we,
    output logic          hit
);
    always_comb begin
        hit = dst_we && (dst != '0) && (src == dst);
    end
endmodule

// File: rtl/fwd_opnd_sel.sv
module fwd_opnd_sel
    import fwd_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic          xm_we,
    input  logic [AW-1:0] xm_rd,
    input  logic          mw_we,
    input  logic [AW-1:0] mw_rd,
    output opnd_sel_e     sel
);
    logic hit_xm;
    logic hit_mw;

    fwd_match #(.AW(AW)) u_xm (.src(src), .dst(xm_rd), .dst_we(xm_we), .hit(hit_xm));
    fwd_match #(.AW(AW)) u_mw (.src(src), .dst(mw_rd), .dst_we(mw_we), .hit(hit_mw));

    always_comb begin
        sel = pick_source(hit_xm, hit_mw);
    end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
    parameter int unsigned AW = 5
) (
    input  logic          is_store,
    input  logic [AW-1:0] st_rs,
    input  logic          mw_we,
    input  logic [AW-1:0] mw_rd,
    output logic          take_wb
);
    logic hit_mw;

    fwd_match #(.AW(AW)) u_mw (.src(st_rs), .dst(mw_rd), .dst_we(mw_we), .hit(hit_mw));

    always_comb begin
        take_wb = is_store && hit_mw;
    end
endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
    import fwd_pkg::*;
#(
    parameter int unsigned ADDR_W = fwd_pkg::REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ex_rs1,
    input  logic [ADDR_W-1:0] ex_rs2,
    input  logic              xm_we,
    input  logic [ADDR_W-1:0] xm_rd,
    input  logic              mw_we,
    input  logic [ADDR_W-1:0] mw_rd,
    input  logic              mem_is_store,
    input  logic [ADDR_W-1:0] mem_st_rs,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic              sel_st
);
    logic [ADDR_W-1:0] opnd_src [N_OPND];
    opnd_sel_e         opnd_sel [N_OPND];

    assign opnd_src[0] = ex_rs1;
    assign opnd_src[1] = ex_rs2;

    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
            fwd_opnd_sel #(.AW(ADDR_W)) u_sel (
                .src   (opnd_src[g]),
                .xm_we (xm_we),
                .xm_rd (xm_rd),
                .mw_we (mw_we),
                .mw_rd (mw_rd),
                .sel   (opnd_sel[g])
            );
        end
    endgenerate

    assign sel_a = opnd_sel[0];
    assign sel_b = opnd_sel[1];

    fwd_store_sel #(.AW(ADDR_W)) u_store (
        .is_store (mem_is_store),
        .st_rs    (mem_st_rs),
        .mw_we    (mw_we),
        .mw_rd    (mw_rd),
        .take_wb  (sel_st)
    );

    // R10: no unused code on either operand select
    p_legal_code_r10: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'd3) && (sel_b != 2'd3));

    // R5: double producer resolves to the execute/memory stage
    p_young_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (xm_we && mw_we && xm_rd == mw_rd && xm_rd != '0 && ex_rs1 == xm_rd) |-> sel_a == 2'd0);

    // R6: with no writer in flight both operands read the register file
    p_no_writer_r6: assert property (@(posedge clk) disable iff (rst)
        (!xm_we && !mw_we) |-> (sel_a == 2'd2 && sel_b == 2'd2 && !sel_st));

    // R7: register 0 is never bypassed
    p_reg_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (ex_rs1 == '0) |-> sel_a == 2'd2);

    // R9: store bypass only for stores
    p_store_only_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_is_store |-> !sel_st);

endmodule

// File: tb/test_fwd_select_unit.sv
module test_fwd_select_unit;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ex_rs1 = '0, ex_rs2 = '0, xm_rd = '0, mw_rd = '0, mem_st_rs = '0;
    logic          xm_we = 1'b0, mw_we = 1'b0, mem_is_store = 1'b0;
    logic [1:0]    sel_a, sel_b;
    logic          sel_st;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fwd_select_unit #(.ADDR_W(AW)) i_fwd_select_unit (
        .clk(clk), .rst(rst), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .xm_we(xm_we), .xm_rd(xm_rd), .mw_we(mw_we), .mw_rd(mw_rd),
        .mem_is_store(mem_is_store), .mem_st_rs(mem_st_rs),
        .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive all fields on a falling edge, then sample mid-low phase.
    task automatic drive(input logic [AW-1:0] r1, input logic [AW-1:0] r2,
                         input logic xw, input logic [AW-1:0] xd,
                         input logic mwe, input logic [AW-1:0] md,
                         input logic st, input logic [AW-1:0] sr);
        @(negedge clk);
        ex_rs1 = r1; ex_rs2 = r2; xm_we = xw; xm_rd = xd;
        mw_we = mwe; mw_rd = md; mem_is_store = st; mem_st_rs = sr;
        #2;
    endtask

    task automatic t_reset;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 reset sel_a", sel_a, 2'd2);
        chk("R3 reset sel_b", sel_b, 2'd2);
        chk("R8 reset sel_st", {1'b0, sel_st}, 2'd0);
    endtask

    task automatic t_xm_only;
        drive(5'd3, 5'd9, 1, 5'd3, 1, 5'd7, 0, 0);
        chk("R1 sel_a from xm", sel_a, 2'd0);
        chk("R4 sel_b independent, no match", sel_b, 2'd2);
    endtask

    task automatic t_mw_only;
        drive(5'd4, 5'd7, 1, 5'd12, 1, 5'd4, 0, 0);
        chk("R2 sel_a from mw", sel_a, 2'd1);
        chk("R3 sel_b from rf", sel_b, 2'd2);
        drive(5'd1, 5'd12, 1, 5'd12, 1, 5'd1, 0, 0);
        chk("R4 sel_b from xm", sel_b, 2'd0);
        chk("R2 sel_a from mw alongside", sel_a, 2'd1);
        drive(5'd8, 5'd6, 0, 5'd0, 1, 5'd6, 0, 0);
        chk("R4 sel_b from mw", sel_b, 2'd1);
        chk("R3 sel_a from rf", sel_a, 2'd2);
    endtask

    task automatic t_priority;
        drive(5'd10, 5'd10, 1, 5'd10, 1, 5'd10, 0, 0);
        chk("R5 sel_a youngest wins", sel_a, 2'd0);
        chk("R5 sel_b youngest wins", sel_b, 2'd0);
    endtask

    task automatic t_enables;
        drive(5'd10, 5'd10, 0, 5'd10, 1, 5'd10, 0, 0);
        chk("R6 xm disabled falls to mw", sel_a, 2'd1);
        drive(5'd10, 5'd10, 0, 5'd10, 0, 5'd10, 1, 5'd10);
        chk("R6 both disabled sel_a", sel_a, 2'd2);
        chk("R6 both disabled sel_b", sel_b, 2'd2);
        chk("R6 disabled mw no store bypass", {1'b0, sel_st}, 2'd0);
    endtask

    task automatic t_zero;
        drive(5'd0, 5'd0, 1, 5'd0, 1, 5'd0, 1, 5'd0);
        chk("R7 r0 sel_a", sel_a, 2'd2);
        chk("R7 r0 sel_b", sel_b, 2'd2);
        chk("R7 r0 store", {1'b0, sel_st}, 2'd0);
    endtask

    task automatic t_store;
        drive(5'd2, 5'd3, 0, 0, 1, 5'd17, 1, 5'd17);
        chk("R8 store bypass taken", {1'b0, sel_st}, 2'd1);
        drive(5'd2, 5'd3, 0, 0, 1, 5'd17, 1, 5'd18);
        chk("R8 store reg differs", {1'b0, sel_st}, 2'd0);
        drive(5'd2, 5'd3, 0, 0, 1, 5'd17, 0, 5'd17);
        chk("R9 non-store ignored", {1'b0, sel_st}, 2'd0);
        drive(5'd2, 5'd3, 1, 5'd17, 0, 5'd0, 1, 5'd17);
        chk("R8 xm match does not feed store", {1'b0, sel_st}, 2'd0);
    endtask

    task automatic t_sweep;
        for (int s = 0; s < 32; s++) begin
            drive(s[AW-1:0], s[AW-1:0], 1, 5'd21, 1, 5'd11, 0, 0);
            chk("R10 legal code a", {1'b0, sel_a == 2'd3}, 2'd0);
            chk("R10 expected a", sel_a, (s == 21) ? 2'd0 : (s == 11) ? 2'd1 : 2'd2);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_xm_only();
        t_mw_only();
        t_priority();
        t_enables();
        t_zero();
        t_store();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule